// File: doc/BRIEF.md
# Calendar Counter with Deferred Register Commit

This block keeps the wall-clock time and the calendar date in two packed 32-bit words. It steps them forward by one second on every pulse of a 1 Hz tick input. Seconds, minutes and hours roll over into the day. The day rolls over into the month according to that month's length. The month rolls over into the year. The leap-year indication is a stored bit that software owns. The counter never computes it.

Software loads new values over a simple register bus. A write does not take effect at once. The value is captured into a holding register for that word and committed into the live counter a fixed number of clock cycles later. While that commit is outstanding, a per-word busy bit in the control word reads as 1, and software polls it before issuing further writes. A tick that arrives while any commit is outstanding is not lost. It is applied once, on top of the committed values, when the last outstanding commit lands.

Top module: `cal_clock`

## Requirements
- R1: The time word at offset 0x14 reads seconds in bits [5:0], minutes in [13:8] and hours in [20:16]; every other bit reads 0, and written bits outside those fields are dropped.
- R2: The date word at offset 0x10 reads day in bits [4:0], month in [11:8], year (offset from 1970) in [21:16] and the leap flag in bit 22; other bits read 0. After reset the date is day 1, month 1, year 0, leap 0 and the time is 00:00:00.
- R3: A write to the time word sets control bit 8 (control word at offset 0x00) from the cycle after the write; the time word keeps its old value while the bit is set.
- R4: A write to the date word sets control bit 7 in the same way; control bit 9 and all other control bits read 0.
- R5: COMMIT_CYCLES (default 3) clock edges after the write edge, the written value appears and the busy bit clears in the same cycle; a new write to the same word while it is busy restarts the wait with the new value.
- R6: Each tick advances seconds; 59 wraps to 0 and carries into minutes, minutes 59 wraps to 0 and carries into hours, hour 23 wraps to 0 and carries into the day. Without a tick or a commit, nothing changes.
- R7: The day wraps to 1 and carries into the month after day 31 in months 1,3,5,7,8,10,12, after day 30 in months 4,6,9,11, and after day 28 in month 2, or day 29 when the leap flag is 1.
- R8: Month 12 wraps to 1 and increments the year; year 63 wraps to 0; the leap flag is never changed by a rollover.
- R9: A tick seen while either commit is outstanding leaves the counter unchanged until the last outstanding commit lands. That one second is then applied to the committed values on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr, combinational |

## Verification
A wrong carry or a wrong month length shows on the read port on the first tick that crosses that boundary. The bench therefore sweeps more than an hour of consecutive seconds across a day boundary, and every month-end for both leap settings. A miscounted commit delay shows as the busy bit or the new value changing one cycle early or late, so it is sampled in every cycle of the window. A lost or doubled deferred tick leaves the time one second off right after the final commit lands.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int WORD_W   = 32;
    localparam int SEC_W    = 6;
    localparam int MIN_W    = 6;
    localparam int HR_W     = 5;
    localparam int DAY_W    = 5;
    localparam int MON_W    = 4;
    localparam int YR_W     = 6;

    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HR_LSB   = 16;
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YR_LSB   = 16;
    localparam int LEAP_BIT = 22;

    localparam int TIME_W   = HR_W + MIN_W + SEC_W;
    localparam int DATE_W   = 1 + YR_W + MON_W + DAY_W;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } tod_t;

    typedef struct packed {
        logic             leap;
        logic [YR_W-1:0]  yr;
        logic [MON_W-1:0] mon;
        logic [DAY_W-1:0] day;
    } ymd_t;

    typedef struct packed {
        ymd_t date;
        tod_t tod;
    } cal_t;

    localparam cal_t CAL_RESET = '{
        date: '{leap: 1'b0, yr: '0, mon: MON_W'(1), day: DAY_W'(1)},
        tod:  '{hr: '0, min: '0, sec: '0}
    };

    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] mon,
                                                   input logic leap);
        logic [DAY_W-1:0] len;
        case (mon)
            MON_W'(2):  len = leap ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): len = DAY_W'(30);
            default:    len = DAY_W'(31);
        endcase
        return len;
    endfunction

    function automatic tod_t word_to_tod(input logic [WORD_W-1:0] w);
        tod_t t;
        t.sec = w[SEC_LSB +: SEC_W];
        t.min = w[MIN_LSB +: MIN_W];
        t.hr  = w[HR_LSB  +: HR_W];
        return t;
    endfunction

    function automatic ymd_t word_to_ymd(input logic [WORD_W-1:0] w);
        ymd_t d;
        d.day  = w[DAY_LSB +: DAY_W];
        d.mon  = w[MON_LSB +: MON_W];
        d.yr   = w[YR_LSB  +: YR_W];
        d.leap = w[LEAP_BIT];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] tod_to_word(input tod_t t);
        logic [WORD_W-1:0] w;
        w = '0;
        w[SEC_LSB +: SEC_W] = t.sec;
        w[MIN_LSB +: MIN_W] = t.min;
        w[HR_LSB  +: HR_W]  = t.hr;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] ymd_to_word(input ymd_t d);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DAY_LSB +: DAY_W] = d.day;
        w[MON_LSB +: MON_W] = d.mon;
        w[YR_LSB  +: YR_W]  = d.yr;
        w[LEAP_BIT]         = d.leap;
        return w;
    endfunction

endpackage

// File: rtl/cal_step.sv
module cal_step
    import cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);

    logic             c_min;
    logic             c_hr;
    logic             c_day;
    logic             c_mon;
    logic             c_yr;
    logic [DAY_W-1:0] last_day;

    always_comb begin
        last_day = month_len(cur.date.mon, cur.date.leap);
        c_min    = cur.tod.sec >= SEC_W'(59);
        c_hr     = c_min && (cur.tod.min >= MIN_W'(59));
        c_day    = c_hr  && (cur.tod.hr  >= HR_W'(23));
        c_mon    = c_day && (cur.date.day >= last_day);
        c_yr     = c_mon && (cur.date.mon >= MON_W'(12));

        nxt = cur;
        nxt.tod.sec = c_min ? '0 : cur.tod.sec + SEC_W'(1);
        if (c_min) begin
            nxt.tod.min = c_hr ? '0 : cur.tod.min + MIN_W'(1);
        end
        if (c_hr) begin
            nxt.tod.hr = c_day ? '0 : cur.tod.hr + HR_W'(1);
        end
        if (c_day) begin
            nxt.date.day = c_mon ? DAY_W'(1) : cur.date.day + DAY_W'(1);
        end
        if (c_mon) begin
            nxt.date.mon = c_yr ? MON_W'(1) : cur.date.mon + MON_W'(1);
        end
        if (c_yr) begin
            nxt.date.yr = cur.date.yr + YR_W'(1);
        end
    end

endmodule

// File: rtl/cal_commit_slot.sv
module cal_commit_slot #(
    parameter int W      = 16,
    parameter int CYCLES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         fire,
    output logic [W-1:0] held
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [W-1:0]     hold;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        fire = (s_q.cnt == CNT_W'(1)) && !load;
        if (load) begin
            s_d.hold = load_val;
            s_d.cnt  = CNT_W'(CYCLES);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.cnt != '0);
    assign held = s_q.hold;

endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter int                COMMIT_CYCLES = 3,
    parameter logic [ADDR_W-1:0] CTRL_OFF      = 'h00,
    parameter logic [ADDR_W-1:0] DATE_OFF      = 'h10,
    parameter logic [ADDR_W-1:0] TIME_OFF      = 'h14,
    parameter int                DATE_BUSY_BIT = 7,
    parameter int                TIME_BUSY_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);

    localparam int SLOT_T = 0;
    localparam int SLOT_D = 1;

    typedef struct packed {
        cal_t cur;
        logic defer;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]        slot_load;
    logic [1:0]        slot_busy;
    logic [1:0]        slot_fire;
    logic [TIME_W-1:0] held_tod;
    logic [DATE_W-1:0] held_ymd;
    cal_t              base;
    cal_t              stepped;
    logic              still_busy;
    logic              want_step;
    logic [31:0]       time_word;
    logic [31:0]       date_word;
    logic [31:0]       ctrl_word;
    logic              unused_wr;

    assign slot_load[SLOT_T] = wr_en && (wr_addr == TIME_OFF);
    assign slot_load[SLOT_D] = wr_en && (wr_addr == DATE_OFF);
    assign unused_wr         = ^wr_data;

    cal_commit_slot #(.W(TIME_W), .CYCLES(COMMIT_CYCLES)) u_tod_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (slot_load[SLOT_T]),
        .load_val (word_to_tod(wr_data)),
        .busy     (slot_busy[SLOT_T]),
        .fire     (slot_fire[SLOT_T]),
        .held     (held_tod)
    );

    cal_commit_slot #(.W(DATE_W), .CYCLES(COMMIT_CYCLES)) u_ymd_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (slot_load[SLOT_D]),
        .load_val (word_to_ymd(wr_data)),
        .busy     (slot_busy[SLOT_D]),
        .fire     (slot_fire[SLOT_D]),
        .held     (held_ymd)
    );

    cal_step u_step (
        .cur (base),
        .nxt (stepped)
    );

    always_comb begin
        base = st_q.cur;
        if (slot_fire[SLOT_T]) begin
            base.tod = tod_t'(held_tod);
        end
        if (slot_fire[SLOT_D]) begin
            base.date = ymd_t'(held_ymd);
        end

        still_busy = (|slot_load) || (|(slot_busy & ~slot_fire));
        want_step  = tick || st_q.defer;

        st_d.cur   = (!still_busy && want_step) ? stepped : base;
        st_d.defer = still_busy && want_step;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cur: CAL_RESET, defer: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        time_word = tod_to_word(st_q.cur.tod);
        date_word = ymd_to_word(st_q.cur.date);
        ctrl_word = '0;
        ctrl_word[TIME_BUSY_BIT] = slot_busy[SLOT_T];
        ctrl_word[DATE_BUSY_BIT] = slot_busy[SLOT_D];
        case (rd_addr)
            CTRL_OFF: rd_data = ctrl_word;
            DATE_OFF: rd_data = date_word;
            TIME_OFF: rd_data = time_word;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk #(
    parameter int                ADDR_W        = 8,
    parameter int                COMMIT_CYCLES = 3,
    parameter logic [ADDR_W-1:0] DATE_OFF      = 'h10,
    parameter logic [ADDR_W-1:0] TIME_OFF      = 'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        busy,
    input logic              defer,
    input logic [31:0]       time_word,
    input logic [31:0]       date_word
);

    logic wr_t;
    logic wr_d;
    int   t_run;

    assign wr_t = wr_en && (wr_addr == TIME_OFF);
    assign wr_d = wr_en && (wr_addr == DATE_OFF);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_run <= 0;
        end else if (wr_t) begin
            t_run <= 1;
        end else if (busy[0]) begin
            t_run <= t_run + 1;
        end else begin
            t_run <= 0;
        end
    end

    // R3
    time_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_t |=> busy[0]);

    // R4
    date_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_d |=> busy[1]);

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy[0] |-> (t_run >= 1 && t_run <= COMMIT_CYCLES));

    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[0] && t_run == COMMIT_CYCLES && !wr_t) |=> !busy[0]);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && busy == 2'b00 && !defer) |=> ($stable(time_word) && $stable(date_word)));

    // R6
    sec_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && busy == 2'b00 && !defer && !wr_en && time_word[5:0] < 6'd59)
        |=> (time_word[5:0] == 6'($past(time_word[5:0]) + 6'd1)));

    // R9
    defer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        defer |-> (busy != 2'b00));

endmodule

bind cal_clock cal_clock_chk #(
    .ADDR_W        (ADDR_W),
    .COMMIT_CYCLES (COMMIT_CYCLES),
    .DATE_OFF      (DATE_OFF),
    .TIME_OFF      (TIME_OFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .busy      (slot_busy),
    .defer     (st_q.defer),
    .time_word (time_word),
    .date_word (date_word)
);

// File: tb/cal_clock_test.sv
module cal_clock_test;

    localparam int PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_DATE = 8'h10;
    localparam logic [7:0] A_TIME = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int y, mo, d, lp, h, mi, s;
    } bt_t;

    cal_clock uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk_time(int h, int m, int s);
        return 32'((h << 16) | (m << 8) | s);
    endfunction

    function automatic logic [31:0] mk_date(int y, int mo, int d, int lp);
        return 32'((lp << 22) | (y << 16) | (mo << 8) | d);
    endfunction

    function automatic int mlen(int mo, int lp);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic bt_t bstep(bt_t t);
        bt_t r = t;
        r.s = t.s + 1;
        if (r.s == 60) begin r.s = 0; r.mi = r.mi + 1; end
        if (r.mi == 60) begin r.mi = 0; r.h = r.h + 1; end
        if (r.h == 24) begin r.h = 0; r.d = r.d + 1; end
        if (r.d > mlen(t.mo, t.lp)) begin r.d = 1; r.mo = r.mo + 1; end
        if (r.mo == 13) begin r.mo = 1; r.y = (r.y + 1) % 64; end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_wait(input logic [7:0] a, input logic [31:0] d);
        wr(a, d);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_all(input bt_t t);
        wr_wait(A_TIME, mk_time(t.h, t.mi, t.s));
        wr_wait(A_DATE, mk_date(t.y, t.mo, t.d, t.lp));
    endtask

    task automatic chk_all(input string req, input bt_t t);
        logic [31:0] v;
        rd(A_TIME, v); chk(req, v, mk_time(t.h, t.mi, t.s));
        rd(A_DATE, v); chk(req, v, mk_date(t.y, t.mo, t.d, t.lp));
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bt_t t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(A_DATE, v); chk("R2 reset date", v, mk_date(0, 1, 1, 0));
        rd(A_TIME, v); chk("R2 reset time", v, 32'h0);
        rd(A_CTRL, v); chk("R4 reset ctrl", v, 32'h0);

        // R3 / R5 busy window on time write
        wr(A_TIME, mk_time(12, 34, 56));
        for (int i = 0; i < 3; i++) begin
            rd(A_CTRL, v); chk("R3 time busy bit8", v, 32'h100);
            rd(A_TIME, v); chk("R3 old time held", v, 32'h0);
            @(negedge clk);
        end
        rd(A_CTRL, v); chk("R5 busy cleared", v, 32'h0);
        rd(A_TIME, v); chk("R5 time committed", v, mk_time(12, 34, 56));

        // R4 date busy, bit 9 stays 0
        wr(A_DATE, mk_date(3, 7, 4, 0));
        for (int i = 0; i < 3; i++) begin
            rd(A_CTRL, v); chk("R4 date busy bit7 only", v, 32'h080);
            rd(A_DATE, v); chk("R4 old date held", v, mk_date(0, 1, 1, 0));
            @(negedge clk);
        end
        rd(A_CTRL, v); chk("R5 date busy cleared", v, 32'h0);
        rd(A_DATE, v); chk("R5 date committed", v, mk_date(3, 7, 4, 0));

        // R1 / R2 bits outside fields dropped
        wr_wait(A_TIME, 32'hFFE0_C0C0 | mk_time(5, 6, 7));
        rd(A_TIME, v); chk("R1 time field mask", v, mk_time(5, 6, 7));
        wr_wait(A_DATE, 32'hFF80_F0E0 | mk_date(9, 10, 11, 1));
        rd(A_DATE, v); chk("R2 date field mask", v, mk_date(9, 10, 11, 1));

        // R5 restart on rewrite while busy
        wr(A_TIME, mk_time(1, 1, 1));
        wr(A_TIME, mk_time(2, 2, 2));
        for (int i = 0; i < 3; i++) begin
            rd(A_CTRL, v); chk("R5 restart busy", v, 32'h100);
            rd(A_TIME, v); chk("R5 restart old value", v, mk_time(5, 6, 7));
            @(negedge clk);
        end
        rd(A_TIME, v); chk("R5 restart final value", v, mk_time(2, 2, 2));

        // R6 no tick, no change
        repeat (20) @(negedge clk);
        rd(A_TIME, v); chk("R6 hold without tick", v, mk_time(2, 2, 2));

        // R6 second sweep across hour and day boundaries
        t = '{y: 10, mo: 3, d: 14, lp: 0, h: 22, mi: 59, s: 0};
        set_all(t);
        for (int i = 0; i < 3720; i++) begin
            pulse();
            t = bstep(t);
            chk_all("R6 sweep", t);
        end

        // R7 / R8 month ends for both leap settings
        for (int lp = 0; lp < 2; lp++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int d = 27; d <= mlen(mo, lp); d++) begin
                    t = '{y: 5, mo: mo, d: d, lp: lp, h: 23, mi: 59, s: 59};
                    set_all(t);
                    pulse();
                    t = bstep(t);
                    chk_all((mo == 12) ? "R8 year carry" : "R7 month end", t);
                end
            end
        end

        // R8 year wrap keeps leap flag
        t = '{y: 63, mo: 12, d: 31, lp: 1, h: 23, mi: 59, s: 59};
        set_all(t);
        pulse();
        chk_all("R8 year wrap", '{y: 0, mo: 1, d: 1, lp: 1, h: 0, mi: 0, s: 0});

        // R9 tick during single pending commit
        wr(A_TIME, mk_time(10, 20, 30));
        pulse();
        rd(A_TIME, v); chk("R9 tick not applied early", v, mk_time(0, 0, 0));
        repeat (2) @(negedge clk);
        rd(A_TIME, v); chk("R9 deferred tick applied", v, mk_time(10, 20, 31));
        repeat (5) @(negedge clk);
        rd(A_TIME, v); chk("R9 applied once", v, mk_time(10, 20, 31));

        // R9 tick while both commits pending
        wr(A_TIME, mk_time(23, 59, 59));
        wr(A_DATE, mk_date(7, 6, 30, 0));
        pulse();
        rd(A_TIME, v); chk("R9 time committed, tick held", v, mk_time(23, 59, 59));
        rd(A_DATE, v); chk("R9 date still old", v, mk_date(0, 1, 1, 1));
        repeat (2) @(negedge clk);
        chk_all("R9 tick after last commit",
                '{y: 7, mo: 7, d: 1, lp: 0, h: 0, mi: 0, s: 0});

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule